// File: doc/BRIEF.md
# Mod-(2^k-1) Residue-Quotient Generator

This block takes an unsigned word of N bits and returns both its remainder and its integer quotient with respect to the modulus m = 2^K - 1, where K is half the word width. It needs no divider. The word is cut into a low half and a high half, and the two halves are added. The sum lies between 0 and 2m. A small correction then removes zero, one or two multiples of m from the sum. The result of that correction is the remainder. The quotient is the high half plus the number of multiples removed.

The block sits beside an arithmetic datapath as an error-detection code source. A test-code path and a result path can each encode their value, and the two codes can then be compared. One register stage separates the input strobe from the output strobe. A parameter picks between two implementations of the correction: a magnitude comparison against m and 2m, or an end-around-carry fold followed by an all-ones test. Both give identical results.

Top module: `rq_mod_gen`

## Requirements
- R1: One clock after `in_valid` is high, `out_r` equals `in_x mod m` as it was sampled at that edge, with m = 2^K - 1.
- R2: One clock after `in_valid` is high, `out_q` equals `floor(in_x / m)`. The all-ones input 2^N - 1 gives 2^K + 1.
- R3: When the sum of the two halves is exactly m or 2m, `out_r` is 0. `out_r` never carries the all-ones value m. Examples are `in_x` = 63 and `in_x` = 4095 with N = 12.
- R4: `out_valid` equals `in_valid` delayed by exactly one clock.
- R5: While `rst_n` is low, `out_valid`, `out_r` and `out_q` are all 0. The reset is asynchronous.
- R6: A clock edge with `in_valid` low leaves `out_r` and `out_q` unchanged, whatever `in_x` carries.
- R7: After each accepted word, `out_q * m + out_r` equals that word and `out_r < m`.
- R8: The comparison correction (`CORR_STYLE` = 0) and the folding correction (`CORR_STYLE` = 1) produce the same `out_r` and `out_q` for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that accepts `in_x` |
| in_x | input | N_BITS | Unsigned word to encode |
| out_valid | output | 1 | Strobe for `out_r` and `out_q` |
| out_r | output | N_BITS/2 | Residue modulo 2^K - 1 |
| out_q | output | N_BITS/2+1 | Quotient by 2^K - 1 |

## Verification
When the half-sum reaches 2m, two actions must happen in the same cycle: the residue is forced to zero, and the quotient is raised by two. The all-ones input provokes this case. A clean sum of m exercises the single-step version of the same case. The bench drives every 12-bit word back to back, with idle gaps mixed in, so the next word is always being captured while the previous result is on the outputs. Each clock, the registered pair is judged against the `%` and `/` operators, against the identity q·m + r = x, and against a second instance that uses the other correction style.

// File: rtl/rq_pkg.sv
`timescale 1ns/1ps
package rq_pkg;
   // selector values for the correction variant
   localparam int RQ_CORR_CMP  = 0;
   localparam int RQ_CORR_FOLD = 1;

   function automatic int rq_modulus(input int k);
      return (1 << k) - 1;
   endfunction
endpackage

// File: rtl/rq_half_sum.sv
`timescale 1ns/1ps
module rq_half_sum #(
   parameter int N_BITS = 12,
   localparam int K = N_BITS / 2
) (
   input  logic [N_BITS-1:0] x,
   output logic [K:0]        sum,
   output logic [K-1:0]      hi
);
   logic [K-1:0] lo_half;

   assign lo_half = x[K-1:0];
   assign hi      = x[N_BITS-1:K];
   assign sum     = {1'b0, lo_half} + {1'b0, hi};
endmodule

// File: rtl/rq_correct.sv
`timescale 1ns/1ps
module rq_correct #(
   parameter int K          = 6,
   parameter int CORR_STYLE = 0
) (
   input  logic [K:0]   sum,
   output logic [K-1:0] rem,
   output logic [1:0]   cnt
);
   import rq_pkg::*;

   generate
      if (CORR_STYLE == RQ_CORR_CMP) begin : g_cmp
         localparam logic [K:0]   M1    = {1'b0, {K{1'b1}}};
         localparam logic [K:0]   M2    = {{K{1'b1}}, 1'b0};
         localparam logic [K-1:0] M1_LO = {K{1'b1}};
         localparam logic [K-1:0] M2_LO = {{(K-1){1'b1}}, 1'b0};

         always_comb begin
            if (sum >= M2) begin
               cnt = 2'd2;
               rem = sum[K-1:0] - M2_LO;
            end else if (sum >= M1) begin
               cnt = 2'd1;
               rem = sum[K-1:0] - M1_LO;
            end else begin
               cnt = 2'd0;
               rem = sum[K-1:0];
            end
         end
      end else begin : g_fold
         logic [K-1:0] folded;
         logic         all_ones;

         // the carry weighs 2^K = m + 1, so it folds back in as +1
         assign folded   = sum[K-1:0] + {{(K-1){1'b0}}, sum[K]};
         assign all_ones = &folded;
         assign rem      = all_ones ? '0 : folded;
         assign cnt      = {1'b0, sum[K]} + {1'b0, all_ones};
      end
   endgenerate
endmodule

// File: rtl/rq_quot_adj.sv
`timescale 1ns/1ps
module rq_quot_adj #(
   parameter int K = 6
) (
   input  logic [K-1:0] hi,
   input  logic [1:0]   cnt,
   output logic [K:0]   q
);
   assign q = {1'b0, hi} + {{(K-1){1'b0}}, cnt};
endmodule

// File: rtl/rq_mod_gen.sv
`timescale 1ns/1ps
module rq_mod_gen #(
   parameter int N_BITS     = 12,
   parameter int CORR_STYLE = 0,
   localparam int K = N_BITS / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [N_BITS-1:0] in_x,
   output logic              out_valid,
   output logic [K-1:0]      out_r,
   output logic [K:0]        out_q
);
   generate
      if ((N_BITS % 2) != 0 || N_BITS < 4 || N_BITS > 30) begin : g_bad_width
         $error("rq_mod_gen: N_BITS must be even and within 4..30");
      end
      if (CORR_STYLE != 0 && CORR_STYLE != 1) begin : g_bad_style
         $error("rq_mod_gen: CORR_STYLE must be 0 or 1");
      end
   endgenerate

   logic [K:0]   half_sum;
   logic [K-1:0] high_half;
   logic [K-1:0] rem_c;
   logic [1:0]   sub_cnt;
   logic [K:0]   quot_c;

   rq_half_sum #(.N_BITS(N_BITS)) u_sum (
      .x   (in_x),
      .sum (half_sum),
      .hi  (high_half)
   );

   rq_correct #(.K(K), .CORR_STYLE(CORR_STYLE)) u_corr (
      .sum (half_sum),
      .rem (rem_c),
      .cnt (sub_cnt)
   );

   rq_quot_adj #(.K(K)) u_qadj (
      .hi  (high_half),
      .cnt (sub_cnt),
      .q   (quot_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_r     <= '0;
         out_q     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_r <= rem_c;
            out_q <= quot_c;
         end
      end
   end
endmodule

// File: rtl/rq_mod_gen_chk.sv
`timescale 1ns/1ps
module rq_mod_gen_chk #(
   parameter int N_BITS = 12,
   localparam int K = N_BITS / 2,
   localparam int M = (1 << K) - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [N_BITS-1:0] in_x,
   input logic              out_valid,
   input logic [K-1:0]      out_r,
   input logic [K:0]        out_q
);
   // R5: reset empties the outputs
   a_r5_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_r == '0 && out_q == '0));

   // R4: strobe delayed by one clock
   a_r4_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r4_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R7, R1, R2: the pair reconstructs the accepted word
   a_r7_identity: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (int'(out_q) * M + int'(out_r) == int'($past(in_x))));

   // R3: residue never carries the all-ones value
   a_r3_no_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_r) != M));

   // R6: idle edges keep the result
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_r) && $stable(out_q)));
endmodule

bind rq_mod_gen rq_mod_gen_chk #(.N_BITS(N_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_x      (in_x),
   .out_valid (out_valid),
   .out_r     (out_r),
   .out_q     (out_q)
);

// File: tb/rq_mod_gen_tb.sv
`timescale 1ns/1ps
module rq_mod_gen_tb;
   localparam int N = 12;
   localparam int K = N / 2;
   localparam int M = (1 << K) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [N-1:0] in_x = '0;
   logic         out_valid, alt_valid;
   logic [K-1:0] out_r, alt_r;
   logic [K:0]   out_q, alt_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   int    exp_v = 0, exp_r = 0, exp_q = 0, exp_x = 0;
   bit    last_accept = 1'b0;
   string rtag = "R5", qtag = "R5";

   always #2.5 clk = ~clk;

   rq_mod_gen #(.N_BITS(N), .CORR_STYLE(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
      .out_valid(out_valid), .out_r(out_r), .out_q(out_q));

   rq_mod_gen #(.N_BITS(N), .CORR_STYLE(1)) u_dut_alt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
      .out_valid(alt_valid), .out_r(alt_r), .out_q(alt_q));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (x=%0d)", tag, act, exp, exp_x);
      end
   endtask

   task automatic compare();
      chk("R4", int'(out_valid), exp_v);
      chk(rtag, int'(out_r), exp_r);
      chk(qtag, int'(out_q), exp_q);
      chk("R8", int'(alt_r), exp_r);
      chk("R8", int'(alt_q), exp_q);
      chk("R8", int'(alt_valid), exp_v);
      if (last_accept) chk("R7", int'(out_q) * M + int'(out_r), exp_x);
   endtask

   task automatic step(input bit v, input int x);
      @(negedge clk);
      compare();
      in_valid = v;
      in_x     = x[N-1:0];
      exp_v    = v;
      last_accept = v;
      if (v) begin
         exp_x = x;
         exp_r = x % M;
         exp_q = x / M;
         rtag  = ((x % M) == 0 && x != 0) ? "R3" : "R1";
         qtag  = (x == (1 << N) - 1) ? "R3" : "R2";
      end else begin
         rtag = "R6";
         qtag = "R6";
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      compare();
      rst_n    = 1'b0;
      in_valid = 1'b0;
      #1;
      chk("R5", int'(out_valid), 0);
      chk("R5", int'(out_r), 0);
      chk("R5", int'(out_q), 0);
      exp_v = 0; exp_r = 0; exp_q = 0;
      last_accept = 1'b0;
      rtag = "R5"; qtag = "R5";
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R5", int'(out_valid), 0);
      chk("R5", int'(out_r), 0);
      chk("R5", int'(out_q), 0);
      rst_n = 1'b1;

      // worked examples and exact-multiple corners
      step(1, 2124);            // R1/R2: r=45 q=33
      step(1, 77);              // r=14 q=1
      step(1, 63);              // R3: sum equals m
      step(1, 4095);            // R3: sum equals 2m, q=65
      step(0, 77);              // R6: idle edge holds 0/65
      step(0, 2124);
      step(1, 0);

      // exhaustive sweep with idle gaps carrying noise on in_x
      for (int x = 0; x < (1 << N); x++) begin
         step(1, x);
         if ((x % 7) == 3) step(0, x ^ 12'hA5A);
      end

      // R5: asynchronous reset while a nonzero result is held
      step(1, 4094);
      do_reset();
      step(0, 1234);
      step(1, 126);
      step(1, 4032);
      step(0, 0);
      @(negedge clk);
      compare();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R4 watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule